// File: doc/BRIEF.md
# Power-On and System Reset Sequencer

This block turns three reset sources into the ordered set of resets that a chip needs at start-up and after a fault. While the active-low power-on reset input is low, it samples the strap pins, holds every PLL in reset with its output gated off, clears the timer registers, drives the bus reset and holds the CPU in reset. Once power-on reset is released, the PLLs are brought up one after another. Each PLL's output is enabled only when its lock indication has been steady for a set number of cycles and the PLL before it is already running. The last PLL in the chain is therefore always the last one enabled. After that, the CPU reset is held for a fixed number of reference-clock cycles, which gives about 100 µs at 250 MHz with the default setting.

A watchdog request and a software request form two more system-reset sources. Each is passed through a two-flop synchroniser and stretched to a minimum width, and then drives the bus reset. Neither one touches the straps, the PLLs or the CPU reset. A small status field reports which source caused the most recent system reset.

Top module: `rst_sequencer`

## Requirements
- R1: While por_n is low, strap_q takes strap_in on every clock edge. Once por_n is high, strap_q holds the last value captured, whatever strap_in does.
- R2: On each edge with por_n low, the outputs are set as follows: pll_rst all ones, pll_out_en all zeros, cpu_rst 1, bus_rst_n 0, tmr_clr 1, strap_le 1, and rst_cause 2'b01.
- R3: At the first edge with por_n high, pll_rst, tmr_clr and strap_le all go to 0.
- R4: PLL index 0 comes first in the bring-up order. For i > 0, pll_out_en[i] rises only after pll_out_en[i-1] has been high. It rises at the edge where pll_lock[i] has been sampled high on LOCK_CYCLES consecutive edges, all while its predecessor was enabled. The highest index is always enabled last.
- R5: If pll_lock[i] is sampled low, pll_out_en[i] drops at that edge. Each later PLL drops one edge after the one before it. Each of them then counts lock again from zero.
- R6: cpu_rst falls exactly CPU_HOLD_CYCLES cycles after the highest pll_out_en bit rises. After that it stays low until the next power-on reset, even if a PLL loses lock.
- R7: Each request input passes through two synchroniser flops. A request that is high across a single edge holds bus_rst_n low for exactly STRETCH_CYCLES cycles. A longer request keeps bus_rst_n low for longer.
- R8: Watchdog and software requests leave strap_q, pll_rst, pll_out_en and cpu_rst unchanged.
- R9: rst_cause records the source of the most recent system reset: 01 for power-on, 10 for watchdog, 11 for software. When both synchronised requests are present at once, watchdog wins. The value holds until a new request arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| por_n | input | 1 | Power-on reset, active low, sampled synchronously |
| wdt_req | input | 1 | Watchdog reset request, asynchronous |
| sw_req | input | 1 | Software reset request, asynchronous |
| strap_in | input | STRAP_W | Strap pin levels |
| pll_lock | input | NUM_PLL | Lock indication per PLL |
| strap_q | output | STRAP_W | Captured strap values |
| strap_le | output | 1 | Strap latch enable, high during power-on reset |
| pll_rst | output | NUM_PLL | Reset to each PLL, active high |
| pll_out_en | output | NUM_PLL | Clock output enable per PLL |
| bus_rst_n | output | 1 | System bus reset, active low |
| tmr_clr | output | 1 | Timer register clear, high during power-on reset |
| cpu_rst | output | 1 | CPU reset, active high |
| rst_cause | output | 2 | Source of the most recent system reset |

## Verification
The locks are presented in a staggered pattern. One PLL is locked before its predecessor is up and another locks only after its predecessor is enabled, which separates the order gating from the lock qualification. A lock drop in the middle of the chain shows whether the cascade reaches only the later stages and whether the CPU release is sticky. The requests are tried as a single-edge pulse, a long hold and a simultaneous pair. These separate the minimum stretch from level extension and show the cause priority. A second power-on reset confirms that everything returns to its initial values.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;
  typedef enum logic [1:0] {
    CAUSE_NONE = 2'b00,
    CAUSE_POR  = 2'b01,
    CAUSE_WDT  = 2'b10,
    CAUSE_SW   = 2'b11
  } cause_e;
endpackage

// File: rtl/rstseq_sync.sv
module rstseq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] ff_q;

  always_ff @(posedge clk) begin
    if (rst) ff_q <= '0;
    else     ff_q <= {ff_q[STAGES-2:0], d};
  end

  assign q = ff_q[STAGES-1];
endmodule

// File: rtl/rstseq_stretch.sv
module rstseq_stretch #(
  parameter int STRETCH_CYCLES = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic req,
  output logic active
);
  localparam int CW = $clog2(STRETCH_CYCLES + 1);
  localparam logic [CW-1:0] LOAD = CW'(STRETCH_CYCLES);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          active_q;

  always_comb begin
    if (req)               cnt_d = LOAD;
    else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
    else                   cnt_d = cnt_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      active_q <= 1'b1;
    end else begin
      cnt_q    <= cnt_d;
      active_q <= (cnt_d != '0);
    end
  end

  assign active = active_q;

  AST_STRETCH_START: assert property (@(posedge clk) disable iff (rst)
    req |=> active) else $error("stretch did not start"); // R7
endmodule

// File: rtl/rstseq_pll_chain.sv
module rstseq_pll_chain #(
  parameter int NUM_PLL     = 3,
  parameter int LOCK_CYCLES = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_PLL-1:0] lock,
  output logic [NUM_PLL-1:0] pll_rst,
  output logic [NUM_PLL-1:0] out_en
);
  localparam int CW = $clog2(LOCK_CYCLES + 1);
  localparam logic [CW-1:0] LOCK_DONE = CW'(LOCK_CYCLES);

  logic [NUM_PLL-1:0] en_q;
  logic [NUM_PLL-1:0] prereq;
  logic [NUM_PLL-1:0] rst_q;

  always_ff @(posedge clk) begin
    if (rst) rst_q <= '1;
    else     rst_q <= '0;
  end

  for (genvar g = 0; g < NUM_PLL; g++) begin : g_stage
    logic [CW-1:0] cnt_q, cnt_d;

    if (g == 0) begin : g_first
      assign prereq[g] = 1'b1;
    end else begin : g_next
      assign prereq[g] = en_q[g-1];
    end

    always_comb begin
      if (!(prereq[g] && lock[g]))  cnt_d = '0;
      else if (cnt_q != LOCK_DONE)  cnt_d = cnt_q + 1'b1;
      else                          cnt_d = cnt_q;
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        cnt_q   <= '0;
        en_q[g] <= 1'b0;
      end else begin
        cnt_q   <= cnt_d;
        en_q[g] <= (cnt_d == LOCK_DONE);
      end
    end

    AST_EN_NEEDS_LOCK: assert property (@(posedge clk) disable iff (rst)
      en_q[g] |-> $past(lock[g])) else $error("enable without lock"); // R5

    if (g > 0) begin : g_order
      AST_EN_ORDER: assert property (@(posedge clk) disable iff (rst)
        $rose(en_q[g]) |-> $past(en_q[g-1])) else $error("out of order"); // R4
    end
  end

  assign out_en  = en_q;
  assign pll_rst = rst_q;
endmodule

// File: rtl/rstseq_cpu_hold.sv
module rstseq_cpu_hold #(
  parameter int HOLD_CYCLES = 25000
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic cpu_rst
);
  localparam int CW = $clog2(HOLD_CYCLES + 1);
  localparam logic [CW-1:0] HOLD_DONE = CW'(HOLD_CYCLES);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cpu_rst_q;

  always_comb begin
    if (cnt_q == HOLD_DONE) cnt_d = cnt_q;
    else if (start)         cnt_d = cnt_q + 1'b1;
    else                    cnt_d = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q     <= '0;
      cpu_rst_q <= 1'b1;
    end else begin
      cnt_q     <= cnt_d;
      cpu_rst_q <= (cnt_d != HOLD_DONE);
    end
  end

  assign cpu_rst = cpu_rst_q;

  AST_CPU_STICKY: assert property (@(posedge clk) disable iff (rst)
    !cpu_rst |=> !cpu_rst) else $error("cpu reset re-asserted"); // R6
endmodule

// File: rtl/rst_sequencer.sv
module rst_sequencer #(
  parameter int NUM_PLL         = 3,
  parameter int STRAP_W         = 8,
  parameter int LOCK_CYCLES     = 8,
  parameter int STRETCH_CYCLES  = 16,
  parameter int CPU_HOLD_CYCLES = 25000
) (
  input  logic               clk,
  input  logic               por_n,
  input  logic               wdt_req,
  input  logic               sw_req,
  input  logic [STRAP_W-1:0] strap_in,
  input  logic [NUM_PLL-1:0] pll_lock,
  output logic [STRAP_W-1:0] strap_q,
  output logic               strap_le,
  output logic [NUM_PLL-1:0] pll_rst,
  output logic [NUM_PLL-1:0] pll_out_en,
  output logic               bus_rst_n,
  output logic               tmr_clr,
  output logic               cpu_rst,
  output logic [1:0]         rst_cause
);
  import rstseq_pkg::*;

  logic               por;
  logic [STRAP_W-1:0] strap_r;
  logic               le_q, clr_q;
  logic               wdt_s, sw_s, ext_active;
  cause_e             cause_q;

  assign por = ~por_n;

  always_ff @(posedge clk) begin
    if (por) begin
      strap_r <= strap_in;
      le_q    <= 1'b1;
      clr_q   <= 1'b1;
      cause_q <= CAUSE_POR;
    end else begin
      le_q    <= 1'b0;
      clr_q   <= 1'b0;
      if (wdt_s)     cause_q <= CAUSE_WDT;
      else if (sw_s) cause_q <= CAUSE_SW;
    end
  end

  rstseq_sync #(.STAGES(2)) u_wdt_sync (
    .clk(clk), .rst(por), .d(wdt_req), .q(wdt_s));

  rstseq_sync #(.STAGES(2)) u_sw_sync (
    .clk(clk), .rst(por), .d(sw_req), .q(sw_s));

  rstseq_stretch #(.STRETCH_CYCLES(STRETCH_CYCLES)) u_stretch (
    .clk(clk), .rst(por), .req(wdt_s | sw_s), .active(ext_active));

  rstseq_pll_chain #(.NUM_PLL(NUM_PLL), .LOCK_CYCLES(LOCK_CYCLES)) u_plls (
    .clk(clk), .rst(por), .lock(pll_lock), .pll_rst(pll_rst), .out_en(pll_out_en));

  rstseq_cpu_hold #(.HOLD_CYCLES(CPU_HOLD_CYCLES)) u_cpu (
    .clk(clk), .rst(por), .start(pll_out_en[NUM_PLL-1]), .cpu_rst(cpu_rst));

  assign strap_q   = strap_r;
  assign strap_le  = le_q;
  assign tmr_clr   = clr_q;
  assign bus_rst_n = ~ext_active;
  assign rst_cause = cause_q;

  AST_STRAP_HOLD: assert property (@(posedge clk) disable iff (por)
    !strap_le |=> $stable(strap_q)) else $error("strap changed"); // R1

  AST_CLR_WITH_PLL: assert property (@(posedge clk) disable iff (por)
    $fell(tmr_clr) |-> $fell(pll_rst[0])) else $error("release skew"); // R3

  AST_CPU_AFTER_LAST: assert property (@(posedge clk) disable iff (por)
    $fell(cpu_rst) |-> $past(pll_out_en[NUM_PLL-1])) else $error("cpu early"); // R6

  AST_BUS_RELEASE: assert property (@(posedge clk) disable iff (por)
    $rose(bus_rst_n) |-> $past(!(wdt_s | sw_s))) else $error("bus released early"); // R7

  AST_CAUSE_KEEP: assert property (@(posedge clk) disable iff (por)
    !(wdt_s | sw_s) |=> $stable(rst_cause)) else $error("cause changed"); // R9
endmodule

// File: tb/rst_sequencer_tb_top.sv
module rst_sequencer_tb_top;
  localparam int NP   = 3;
  localparam int SW   = 8;
  localparam int LOCK = 8;
  localparam int STR  = 16;
  localparam int DLY  = 25000;

  logic          clk = 1'b0;
  logic          por_n, wdt_req, sw_req;
  logic [SW-1:0] strap_in;
  logic [NP-1:0] pll_lock;
  logic [SW-1:0] strap_q;
  logic          strap_le, bus_rst_n, tmr_clr, cpu_rst;
  logic [NP-1:0] pll_rst, pll_out_en;
  logic [1:0]    rst_cause;

  always #2 clk = ~clk;

  rst_sequencer #(.NUM_PLL(NP), .STRAP_W(SW), .LOCK_CYCLES(LOCK),
                  .STRETCH_CYCLES(STR), .CPU_HOLD_CYCLES(DLY)) dut_i (
    .clk(clk), .por_n(por_n), .wdt_req(wdt_req), .sw_req(sw_req),
    .strap_in(strap_in), .pll_lock(pll_lock), .strap_q(strap_q),
    .strap_le(strap_le), .pll_rst(pll_rst), .pll_out_en(pll_out_en),
    .bus_rst_n(bus_rst_n), .tmr_clr(tmr_clr), .cpu_rst(cpu_rst),
    .rst_cause(rst_cause));

  int checks = 0;
  int fails  = 0;
  bit started = 0;
  bit done = 0;

  // behavioural reference model
  logic [SW-1:0] m_strap;
  bit   m_le, m_clr, m_bus, m_cpurst;
  bit   [NP-1:0] m_pllrst, m_en, oen;
  int   m_cnt [NP];
  int   m_cpu, m_str, m_cause;
  bit   m_w1, m_w2, m_s1, m_s2, ow2, os2;

  always @(posedge clk) begin
    if (!por_n) begin
      m_strap = strap_in; m_le = 1; m_clr = 1; m_pllrst = '1; m_en = '0;
      for (int i = 0; i < NP; i++) m_cnt[i] = 0;
      m_cpu = 0; m_cpurst = 1; m_str = 0; m_bus = 0; m_cause = 1;
      m_w1 = 0; m_w2 = 0; m_s1 = 0; m_s2 = 0;
      started = 1;
    end else if (started) begin
      oen = m_en; ow2 = m_w2; os2 = m_s2;
      m_le = 0; m_clr = 0; m_pllrst = '0;
      for (int i = 0; i < NP; i++) begin
        if (((i == 0) || oen[i-1]) && pll_lock[i]) begin
          if (m_cnt[i] < LOCK) m_cnt[i]++;
        end else m_cnt[i] = 0;
        m_en[i] = (m_cnt[i] == LOCK);
      end
      if (oen[NP-1]) begin
        if (m_cpu < DLY) m_cpu++;
      end else if (m_cpu != DLY) m_cpu = 0;
      m_cpurst = (m_cpu != DLY);
      if (ow2 || os2) m_str = STR;
      else if (m_str > 0) m_str--;
      m_bus = (m_str == 0);
      if (ow2) m_cause = 2;
      else if (os2) m_cause = 3;
      m_w2 = m_w1; m_w1 = wdt_req; m_s2 = m_s1; m_s1 = sw_req;
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (started && !done) begin
      chk(strap_q === m_strap, "R1 strap_q", strap_q, m_strap);
      chk(strap_le === m_le, "R2 strap_le", strap_le, m_le);
      chk(tmr_clr === m_clr, "R3 tmr_clr", tmr_clr, m_clr);
      chk(pll_rst === m_pllrst, "R3 pll_rst", pll_rst, m_pllrst);
      chk(pll_out_en === m_en, "R4 pll_out_en", pll_out_en, m_en);
      chk(cpu_rst === m_cpurst, "R6 cpu_rst", cpu_rst, m_cpurst);
      chk(bus_rst_n === m_bus, "R7 bus_rst_n", bus_rst_n, m_bus);
      chk(rst_cause === m_cause[1:0], "R9 rst_cause", rst_cause, m_cause);
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog timeout actual=1 expected=0");
    finish_run();
  end

  initial begin
    int n;
    por_n = 0; wdt_req = 0; sw_req = 0; pll_lock = '0; strap_in = 8'hA5;
    wait_cyc(4);
    // R2 reset state
    chk(pll_rst === 3'b111 && pll_out_en === 3'b000, "R2 plls held", {pll_rst, pll_out_en}, 6'b111000);
    chk(cpu_rst === 1 && bus_rst_n === 0 && tmr_clr === 1, "R2 resets", {cpu_rst, bus_rst_n, tmr_clr}, 3'b101);
    chk(rst_cause === 2'b01 && strap_le === 1, "R2 cause", rst_cause, 2'b01);
    strap_in = 8'h5A;
    wait_cyc(2);
    chk(strap_q === 8'h5A, "R1 capture", strap_q, 8'h5A);
    pll_lock = 3'b010;                      // PLL1 locked before its predecessor
    por_n = 1;
    wait_cyc(1);
    chk(pll_rst === 3'b000 && tmr_clr === 0 && strap_le === 0, "R3 release",
        {pll_rst, tmr_clr, strap_le}, 5'b0);
    strap_in = 8'hFF;
    wait_cyc(2);
    pll_lock[0] = 1'b1;
    while (!pll_out_en[1]) @(negedge clk);
    chk(pll_out_en === 3'b011, "R4 order 0 then 1", pll_out_en, 3'b011);
    wait_cyc(2);
    pll_lock[2] = 1'b1;                     // lock arrives after predecessor is up
    while (!pll_out_en[2]) @(negedge clk);
    chk(pll_out_en === 3'b111, "R4 last enabled last", pll_out_en, 3'b111);
    n = 0;
    while (cpu_rst) begin n++; @(negedge clk); end
    chk(n == DLY, "R6 cpu hold length", n, DLY);
    chk(strap_q === 8'h5A, "R1 strap held", strap_q, 8'h5A);
    // R5 lock loss in the middle
    pll_lock[1] = 1'b0;
    wait_cyc(2);
    chk(pll_out_en === 3'b001, "R5 cascade drop", pll_out_en, 3'b001);
    chk(cpu_rst === 0, "R6 cpu stays released", cpu_rst, 0);
    pll_lock[1] = 1'b1;
    wait_cyc(2 * LOCK + 4);
    chk(pll_out_en === 3'b111, "R5 relock", pll_out_en, 3'b111);
    // R7 single-edge watchdog pulse
    wdt_req = 1; wait_cyc(1); wdt_req = 0;
    while (bus_rst_n) @(negedge clk);
    chk(pll_rst === 3'b000 && pll_out_en === 3'b111 && cpu_rst === 0, "R8 plls and cpu untouched",
        {pll_rst, pll_out_en, cpu_rst}, 7'b0001110);
    n = 0;
    while (!bus_rst_n) begin n++; @(negedge clk); end
    chk(n == STR, "R7 stretch length", n, STR);
    chk(rst_cause === 2'b10, "R9 watchdog cause", rst_cause, 2'b10);
    chk(strap_q === 8'h5A, "R8 strap untouched", strap_q, 8'h5A);
    // long software request
    wait_cyc(5);
    sw_req = 1; wait_cyc(20); sw_req = 0;
    wait_cyc(STR + 8);
    chk(rst_cause === 2'b11, "R9 software cause", rst_cause, 2'b11);
    chk(bus_rst_n === 1, "R7 released after long request", bus_rst_n, 1);
    // simultaneous requests
    wdt_req = 1; sw_req = 1; wait_cyc(1); wdt_req = 0; sw_req = 0;
    wait_cyc(STR + 8);
    chk(rst_cause === 2'b10, "R9 watchdog priority", rst_cause, 2'b10);
    // second power-on reset
    por_n = 0;
    wait_cyc(3);
    chk(rst_cause === 2'b01 && pll_out_en === 3'b000 && cpu_rst === 1, "R2 second por",
        {rst_cause, pll_out_en, cpu_rst}, 6'b010001);
    chk(strap_q === 8'hFF, "R1 recapture", strap_q, 8'hFF);
    por_n = 1;
    wait_cyc(5);
    finish_run();
  end
endmodule